// File: doc/BRIEF.md
# Three-Vector Dwell-Time PWM Sequencer

The sequencer plays back one triangle of a space-vector modulation scheme in every modulation period. A host computes three 5-bit voltage-vector codes and two dwell times. It writes them into shadow registers through a simple write port. A free-running period counter then steps the output through the first vector, the second vector and the third vector, always in that order. The dwell of the third vector is never supplied: it is whatever remains of the period after the first two.

The block compares the counter with the first dwell and with the sum of both dwells to choose the active vector. It reports the active code, a 2-bit phase number and a one-cycle strobe at the start of each period. The shadow contents move to the active set only on the period wrap, so the host may write at any time without tearing a period. Finding the region and computing the dwells happen in the host. Turning a vector code into gate signals happens downstream. At a 125 MHz clock, a 2 kHz switching rate corresponds to a period value of 62500.

Top module: `svm_dwell_seq`

## Requirements
- R1: A synchronous reset forces the output code to ZERO_CODE (default 0). It clears the period counter, holds `period_start` low and loads the period with RST_PERIOD. Both dwells and all three shadow and active codes reset to 0 and ZERO_CODE.
- R2: The counter runs from 0 up to period-1 and then wraps to 0. `period_start` is high for exactly the first cycle (count 0) of each period that follows a wrap.
- R3: While count < t1, the output is the first vector code and `phase` is 0.
- R4: While t1 <= count < t1+t2, the output is the second vector code and `phase` is 1.
- R5: From count = t1+t2 to the end of the period, the output is the third vector code and `phase` is 2. `phase` never reads 3.
- R6: Writes land in shadow registers. The active period, dwells and codes change only at the wrap, so the first cycle showing new values is the one in which `period_start` is high. Within a period, `phase` never decreases.
- R7: The dwell boundaries are clipped to the period. If t1 is at least the period, only the first vector is output. If t1+t2 is at least the period, the third vector gets no cycles.
- R8: A zero t1 or zero t2 skips that vector entirely: its phase value does not appear in that period.
- R9: The write select decodes as 0 period, 1 t1, 2 t2, 3 first code, 4 second code, 5 third code. Codes take the low 5 bits of `wr_data`. Selects 6 and 7 change nothing.
- R10: A period value of 0 behaves as a one-cycle period. In that case `period_start` is high on every cycle once it is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Shadow register write strobe |
| wr_sel | input | 3 | Shadow register select (see R9) |
| wr_data | input | CNT_W (16) | Write data; codes use the low CODE_W bits |
| vec_code | output | CODE_W (5) | Active voltage-vector code |
| phase | output | 2 | Active vector index: 0, 1 or 2 |
| period_start | output | 1 | High in the first cycle of each new period |

## Verification
The code and phase outputs are decoded directly from the counter register and the active set. Each therefore changes in the same cycle the counter does, one clock edge after the previous count. A shadow write reaches the outputs in the cycle after the wrap edge, which is also the cycle in which `period_start` is high. The bench drives inputs on falling edges and advances a behavioural model on each rising edge. On every falling edge it compares the code, the phase and the strobe with the model, so each comparison lands half a cycle after the register update it depends on.

// File: rtl/svm_dwell_seq.sv
module svm_dwell_seq #(
  parameter int CODE_W     = 5,
  parameter int CNT_W      = 16,
  parameter int RST_PERIOD = 62500,
  parameter int ZERO_CODE  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CODE_W-1:0] vec_code,
  output logic [1:0]        phase,
  output logic              period_start
);

  localparam logic [CNT_W-1:0]  PER_INIT = CNT_W'(RST_PERIOD);
  localparam logic [CODE_W-1:0] ZCODE    = CODE_W'(ZERO_CODE);

  logic [CNT_W-1:0]  per_s, t1_s, t2_s, per_a, t1_a, t2_a, cnt, last, e1, e2;
  logic [CODE_W-1:0] v1_s, v2_s, v3_s, v1_a, v2_a, v3_a;
  logic [CNT_W:0]    sum;
  logic              wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_s <= PER_INIT;
      t1_s  <= '0;
      t2_s  <= '0;
      v1_s  <= ZCODE;
      v2_s  <= ZCODE;
      v3_s  <= ZCODE;
    end else if (wr_en) begin
      case (wr_sel)
        3'd0: per_s <= wr_data;
        3'd1: t1_s  <= wr_data;
        3'd2: t2_s  <= wr_data;
        3'd3: v1_s  <= wr_data[CODE_W-1:0];
        3'd4: v2_s  <= wr_data[CODE_W-1:0];
        3'd5: v3_s  <= wr_data[CODE_W-1:0];
        default: ;
      endcase
    end
  end

  assign last = (per_a == '0) ? '0 : per_a - 1'b1;
  assign wrap = (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt          <= '0;
      period_start <= 1'b0;
      per_a        <= PER_INIT;
      t1_a         <= '0;
      t2_a         <= '0;
      v1_a         <= ZCODE;
      v2_a         <= ZCODE;
      v3_a         <= ZCODE;
    end else begin
      period_start <= wrap;
      if (wrap) begin
        cnt   <= '0;
        per_a <= per_s;
        t1_a  <= t1_s;
        t2_a  <= t2_s;
        v1_a  <= v1_s;
        v2_a  <= v2_s;
        v3_a  <= v3_s;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign sum = {1'b0, t1_a} + {1'b0, t2_a};
  assign e1  = (t1_a > per_a) ? per_a : t1_a;
  assign e2  = (sum > {1'b0, per_a}) ? per_a : sum[CNT_W-1:0];

  assign phase = (cnt < e1) ? 2'd0 : (cnt < e2) ? 2'd1 : 2'd2;

  always_comb begin
    case (phase)
      2'd0:    vec_code = v1_a;
      2'd1:    vec_code = v2_a;
      default: vec_code = v3_a;
    endcase
  end

endmodule

// File: rtl/svm_dwell_seq_chk.sv
module svm_dwell_seq_chk #(
  parameter int CODE_W    = 5,
  parameter int CNT_W     = 16,
  parameter int ZERO_CODE = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              period_start,
  input logic [1:0]        phase,
  input logic [CODE_W-1:0] vec_code,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  t1_a,
  input logic [CODE_W-1:0] v1_a
);

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (vec_code == CODE_W'(ZERO_CODE) && !period_start));

  // R2
  strobe_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    period_start |-> cnt == '0);

  // R5
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase != 2'd3);

  // R6
  active_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!period_start && !$past(rst)) |-> $stable(v1_a));

  // R6
  phase_order_chk: assert property (@(posedge clk) disable iff (rst)
    (!period_start && !$past(rst)) |-> phase >= $past(phase));

  // R3
  first_window_chk: assert property (@(posedge clk) disable iff (rst)
    phase == 2'd0 |-> cnt < t1_a);

endmodule

bind svm_dwell_seq svm_dwell_seq_chk #(
  .CODE_W(CODE_W), .CNT_W(CNT_W), .ZERO_CODE(ZERO_CODE)
) u_chk (
  .clk(clk), .rst(rst), .period_start(period_start), .phase(phase),
  .vec_code(vec_code), .cnt(cnt), .t1_a(t1_a), .v1_a(v1_a)
);

// File: tb/tb_svm_dwell_seq.sv
module tb_svm_dwell_seq;
  localparam int CODE_W = 5;
  localparam int CNT_W  = 16;
  localparam int RSTP   = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [2:0]        wr_sel = '0;
  logic [CNT_W-1:0]  wr_data = '0;
  logic [CODE_W-1:0] vec_code;
  logic [1:0]        phase;
  logic              period_start;

  svm_dwell_seq #(.CODE_W(CODE_W), .CNT_W(CNT_W), .RST_PERIOD(RSTP), .ZERO_CODE(0)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .vec_code(vec_code), .phase(phase), .period_start(period_start)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit started = 0, done = 0;
  string scen = "R1";

  int m_cnt, m_ps;
  int sh[6];
  int ac[6];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", tag, scen, $time, act, exp);
    end
  endtask

  function automatic int exp_phase();
    int e1, e2;
    e1 = (ac[1] > ac[0]) ? ac[0] : ac[1];
    e2 = (ac[1] + ac[2] > ac[0]) ? ac[0] : ac[1] + ac[2];
    if (m_cnt < e1) return 0;
    if (m_cnt < e2) return 1;
    return 2;
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_cnt = 0; m_ps = 0;
      sh[0] = RSTP; ac[0] = RSTP;
      for (int i = 1; i < 6; i++) begin sh[i] = 0; ac[i] = 0; end
    end else begin
      int last;
      last = (ac[0] == 0) ? 0 : ac[0] - 1;
      if (m_cnt >= last) begin
        m_cnt = 0; m_ps = 1;
        for (int i = 0; i < 6; i++) ac[i] = sh[i];
      end else begin
        m_cnt++; m_ps = 0;
      end
      if (wr_en && wr_sel < 6)
        sh[wr_sel] = (wr_sel >= 3) ? (int'(wr_data) & 31) : int'(wr_data);
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      int p, c;
      p = exp_phase();
      c = ac[3 + p];
      chk(period_start == m_ps[0], "R2 strobe", period_start, m_ps);
      chk(phase == p[1:0], (p == 0) ? "R3 phase" : (p == 1) ? "R4 phase" : "R5 phase", phase, p);
      chk(vec_code == c[CODE_W-1:0], (p == 0) ? "R3 code" : (p == 1) ? "R4 code" : "R5 code",
          vec_code, c);
    end
  end

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = CNT_W'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input int per, input int t1, input int t2, input int a, input int b, input int c);
    wr(0, per); wr(1, t1); wr(2, t2); wr(3, a); wr(4, b); wr(5, c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(vec_code == 0, "R1 reset code", vec_code, 0);
    chk(period_start == 0, "R1 reset strobe", period_start, 0);
    rst = 1'b0;
    idle(12);

    scen = "R3 R4 R5 basic";
    load(8, 3, 2, 13, 14, 1);
    idle(30);

    scen = "R6 mid-period write";
    wait (period_start == 1'b1);
    @(negedge clk);
    wr(3, 7); wr(1, 5);
    idle(25);

    scen = "R8 zero t1";
    load(9, 0, 4, 2, 3, 4);
    idle(25);
    scen = "R8 zero t2";
    wr(1, 4); wr(2, 0);
    idle(25);

    scen = "R7 sum over period";
    load(6, 4, 5, 21, 22, 23);
    idle(20);
    scen = "R7 t1 over period";
    wr(1, 9);
    idle(20);

    scen = "R9 ignored selects";
    wr(6, 3); wr(7, 1);
    idle(20);
    wr(6, 1234); wr(7, 31);
    idle(10);

    scen = "R10 zero period";
    load(0, 0, 0, 5, 6, 9);
    idle(12);
    scen = "R10 one-cycle period";
    load(1, 1, 0, 11, 12, 17);
    idle(12);

    scen = "R1 mid-run reset";
    load(7, 2, 2, 3, 4, 5);
    idle(10);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk(vec_code == 0, "R1 reset code", vec_code, 0);
    rst = 1'b0;
    idle(25);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule